// File: doc/BRIEF.md
# Ethernet MAC Control Register Bank

This block is the software-visible control and status bank of an Ethernet MAC. A simple word-oriented memory-mapped bus reads and writes it. Each location has its own write rule. Some bits clear when written as 1, some are forced to constants, some fields are masked away, and some registers are read-only. Writes to the control register have side effects on the rest of the bank.

The bank raises a level interrupt whenever an enabled event is pending. It issues one-cycle start strobes to the transmit and receive descriptor engines. It shows the current descriptor pointers of both rings. The engines and other logic set event bits through a set-vector input.

A PHY management frame register hands each written frame to an external management engine. When that engine reports completion, the register stores any read data and raises the management event.

Top module: `emac_regfile`

## Requirements
- R1: The word index is the byte address shifted right by two. Reads return the selected register combinationally. After reset these indices read the values shown, and every other mapped index reads 0:
  - control (9): 0xF0000000
  - statistics control (25): 0xC0000000
  - receive control (33): 0x05EE0001
  - station low (57): station address bits 47:16
  - station high (58): station address bits 15:0 in the upper half, 0x8808 in the lower half
  - pause/opcode (59): 0x00010000
  - FIFO bound (83): 0x600
  - FIFO start (84): 0x500
  - interface enable (194): 0x6
- R2: Event register (index 1). A bit written as 1 clears, a bit written as 0 is unchanged. The set vector input ORs bits in. When a set and a clear of the same bit fall in one cycle, the set wins.
- R3: `irq` is high exactly when the event register AND the mask register (index 2) is nonzero.
- R4: Control register (index 9):
  - A write with bit 0 set restores every register and both pointers to their reset values.
  - Otherwise the value is stored.
  - If that stored value has bit 1 (enable) clear, the receive-active flag clears and both pointers reload from their ring-start registers.
- R5: A write to receive-active (index 4) while enabled and inactive sets it to read 0x01000000 and pulses `rx_start` for one cycle. While enabled and already active, the write has no effect. While disabled, the write clears the flag.
- R6: A write to transmit-active (index 5) pulses `tx_start` only while enabled. Index 5 always reads 0.
- R7: Write masks:
  - mask (2) and station low (57) store the value as written.
  - speed (17) keeps 0xFE.
  - receive control (33) keeps 0x07FF003F.
  - watermark (81) keeps bits 1:0.
  - FIFO start (84) keeps 0x3FC and forces 0x400.
  - maximum receive buffer (98) keeps 0x7F0.
  - interface configuration (192) keeps 0x53.
  - pause/opcode (59) keeps the low 16 bits and forces bit 16.
  - station high (58) stores (value | 0xFFFF) & 0xFFFF8808.
- R8: Statistics control (25) stores 0xC0000000 if bit 31 is written as 1, otherwise 0. Interface enable (194) stores 0x6 if bit 1 is written as 1, otherwise 0. FIFO bound (83) ignores writes.
- R9: A transmit control (49) write stores the value. If bit 0 is 1, it also sets event bit `EV_GRA` (default 28).
- R10: A management frame (16) write stores the value and pulses `mgmt_req` in the next cycle, with these fields:
  - `mgmt_rd` is bit 29.
  - `mgmt_addr` is bits 27:18.
  - `mgmt_wdata` is bits 15:0.

  On `mgmt_done`, a read frame takes `mgmt_rdata` into bits 15:0, and event bit `EV_MII` (default 23) is set.
- R11: An unmapped index reads 0 and ignores writes. Any access to one gives a one-cycle `bus_err` in the cycle after the access.
- R12: A ring-start write (96 receive, 97 transmit) stores the value with bits 1:0 cleared. The matching pointer output takes the same value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_err | output | 1 | Unmapped access, one cycle after |
| ev_set | input | 32 | Event bits to set this cycle |
| irq | output | 1 | Level interrupt |
| rx_start | output | 1 | Receive descriptor start strobe |
| tx_start | output | 1 | Transmit descriptor start strobe |
| rx_desc_ptr | output | 32 | Current receive descriptor pointer |
| tx_desc_ptr | output | 32 | Current transmit descriptor pointer |
| mgmt_req | output | 1 | Management frame request strobe |
| mgmt_rd | output | 1 | Management frame is a read |
| mgmt_addr | output | 10 | PHY and register address |
| mgmt_wdata | output | 16 | Management write data |
| mgmt_done | input | 1 | Management frame complete |
| mgmt_rdata | input | 16 | Management read data |

## Verification
A write takes effect at the clock edge where it is presented. The readback, `irq` and both pointers change at that same edge. The strobes `rx_start`, `tx_start`, `mgmt_req` and `bus_err` are registered and are high for exactly the one cycle after that edge. Read data is combinational in the access cycle. The bench drives every access on a falling edge and samples read data shortly after driving it. It samples strobes and levels on the next falling edge, so each result is taken inside its single valid cycle.

// File: rtl/emac_regfile.sv
module emac_regfile #(
  parameter int          ADDR_W       = 10,
  parameter logic [47:0] STATION_ADDR = 48'h02005E102030,
  parameter int          EV_MII       = 23,
  parameter int          EV_GRA       = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [31:0]       ev_set,
  output logic              irq,
  output logic              rx_start,
  output logic              tx_start,
  output logic [31:0]       rx_desc_ptr,
  output logic [31:0]       tx_desc_ptr,
  output logic              mgmt_req,
  output logic              mgmt_rd,
  output logic [9:0]        mgmt_addr,
  output logic [15:0]       mgmt_wdata,
  input  logic              mgmt_done,
  input  logic [15:0]       mgmt_rdata
);
  localparam int I_EVT = 1,  I_MSK = 2,  I_RXA = 4,  I_TXA = 5,  I_CTL = 9;
  localparam int I_MMF = 16, I_SPD = 17, I_MIB = 25, I_RCR = 33, I_TCR = 49;
  localparam int I_PAL = 57, I_PAU = 58, I_OPD = 59, I_TFW = 81, I_FBD = 83;
  localparam int I_FST = 84, I_RDS = 96, I_TDS = 97, I_MRB = 98, I_GCF = 192;
  localparam int I_GEN = 194;

  typedef struct packed {
    logic [31:0] evt, mask, ctl, mmf, spd, rcr, tcr, pal, pau, opd;
    logic [31:0] tfw, fst, rds, tds, mrb, gcf, rxp, txp;
    logic        rxa, mib, gen, rxs, txs, err, mreq;
  } st_t;

  localparam st_t RST = '{ctl: 32'hF000_0000, rcr: 32'h05EE_0001,
                          pal: STATION_ADDR[47:16],
                          pau: {STATION_ADDR[15:0], 16'h8808},
                          opd: 32'h0001_0000, fst: 32'h0000_0500,
                          mib: 1'b1, gen: 1'b1, default: '0};

  st_t r, n;
  logic [31:0] rd, set_v, clr_v;
  logic        hit;

  wire [ADDR_W-3:0] idx = bus_addr[ADDR_W-1:2];
  wire unused_lo = ^bus_addr[1:0];
  wire we = bus_sel & bus_wr;
  wire soft_rst = we && (int'(idx) == I_CTL) && bus_wdata[0];

  always_comb begin
    hit = 1'b1;
    rd  = '0;
    case (int'(idx))
      I_EVT: rd = r.evt;
      I_MSK: rd = r.mask;
      I_RXA: rd = {7'b0, r.rxa, 24'b0};
      I_TXA: rd = '0;
      I_CTL: rd = r.ctl;
      I_MMF: rd = r.mmf;
      I_SPD: rd = r.spd;
      I_MIB: rd = {r.mib, r.mib, 30'b0};
      I_RCR: rd = r.rcr;
      I_TCR: rd = r.tcr;
      I_PAL: rd = r.pal;
      I_PAU: rd = r.pau;
      I_OPD: rd = r.opd;
      I_TFW: rd = r.tfw;
      I_FBD: rd = 32'h0000_0600;
      I_FST: rd = r.fst;
      I_RDS: rd = r.rds;
      I_TDS: rd = r.tds;
      I_MRB: rd = r.mrb;
      I_GCF: rd = r.gcf;
      I_GEN: rd = {29'b0, r.gen, r.gen, 1'b0};
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    n = r;
    n.rxs = 1'b0; n.txs = 1'b0; n.err = 1'b0; n.mreq = 1'b0;
    set_v = ev_set;
    clr_v = '0;
    if (mgmt_done) begin
      set_v[EV_MII] = 1'b1;
      if (r.mmf[29]) n.mmf[15:0] = mgmt_rdata;
    end
    if (we) begin
      case (int'(idx))
        I_EVT: clr_v = bus_wdata;
        I_MSK: n.mask = bus_wdata;
        I_RXA: begin
          if (!r.ctl[1]) n.rxa = 1'b0;
          else if (!r.rxa) begin n.rxa = 1'b1; n.rxs = 1'b1; end
        end
        I_TXA: n.txs = r.ctl[1];
        I_CTL: begin
          n.ctl = bus_wdata;
          if (!bus_wdata[1]) begin
            n.rxa = 1'b0;
            n.rxp = r.rds;
            n.txp = r.tds;
          end
        end
        I_MMF: begin n.mmf = bus_wdata; n.mreq = 1'b1; end
        I_SPD: n.spd = bus_wdata & 32'h0000_00FE;
        I_MIB: n.mib = bus_wdata[31];
        I_RCR: n.rcr = bus_wdata & 32'h07FF_003F;
        I_TCR: begin
          n.tcr = bus_wdata;
          if (bus_wdata[0]) set_v[EV_GRA] = 1'b1;
        end
        I_PAL: n.pal = bus_wdata;
        I_PAU: n.pau = (bus_wdata | 32'h0000_FFFF) & 32'hFFFF_8808;
        I_OPD: n.opd = {15'b0, 1'b1, bus_wdata[15:0]};
        I_TFW: n.tfw = bus_wdata & 32'h3;
        I_FST: n.fst = (bus_wdata & 32'h3FC) | 32'h400;
        I_RDS: begin n.rds = {bus_wdata[31:2], 2'b0}; n.rxp = {bus_wdata[31:2], 2'b0}; end
        I_TDS: begin n.tds = {bus_wdata[31:2], 2'b0}; n.txp = {bus_wdata[31:2], 2'b0}; end
        I_MRB: n.mrb = bus_wdata & 32'h7F0;
        I_GCF: n.gcf = bus_wdata & 32'h53;
        I_GEN: n.gen = bus_wdata[1];
        default: ;
      endcase
    end
    n.evt = (r.evt & ~clr_v) | set_v;
    n.err = bus_sel & ~hit;
    if (soft_rst) n = RST;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) r <= RST;
    else        r <= n;

  assign bus_rdata   = rd;
  assign bus_err     = r.err;
  assign irq         = |(r.evt & r.mask);
  assign rx_start    = r.rxs;
  assign tx_start    = r.txs;
  assign rx_desc_ptr = r.rxp;
  assign tx_desc_ptr = r.txp;
  assign mgmt_req    = r.mreq;
  assign mgmt_rd     = r.mmf[29];
  assign mgmt_addr   = r.mmf[27:18];
  assign mgmt_wdata  = r.mmf[15:0];
endmodule

// File: rtl/emac_regfile_chk.sv
module emac_regfile_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       ev_set,
  input logic              mgmt_done,
  input logic              irq,
  input logic              rx_start,
  input logic              tx_start,
  input logic              bus_err,
  input logic              mgmt_req,
  input logic [31:0]       rx_desc_ptr
);
  wire [ADDR_W-3:0] widx = bus_addr[ADDR_W-1:2];
  wire unused_lo = ^bus_addr[1:0];
  wire wr_now = bus_sel & bus_wr;

  // R6
  tx_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(wr_now && widx == (ADDR_W-2)'(5)));

  // R5
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> !rx_start);

  // R11
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

  // R10
  mgmt_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |-> $past(wr_now && widx == (ADDR_W-2)'(16)));

  // R4
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && widx == (ADDR_W-2)'(9) && bus_wdata[0]) |=> (!irq && rx_desc_ptr == 32'h0));

  // R2
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && widx == (ADDR_W-2)'(1) && bus_wdata == 32'hFFFF_FFFF
     && ev_set == 32'h0 && !mgmt_done) |=> !irq);
endmodule

bind emac_regfile emac_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_emac_regfile.sv
module tb_emac_regfile;
  localparam int CLK_P = 10;
  localparam int ADDR_W = 10;
  localparam logic [47:0] STA = 48'h02005E102030;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_err, irq, rx_start, tx_start, mgmt_req, mgmt_rd;
  logic [31:0] ev_set = '0, rx_desc_ptr, tx_desc_ptr;
  logic [9:0]  mgmt_addr;
  logic [15:0] mgmt_wdata, mgmt_rdata = '0;
  logic        mgmt_done = 1'b0;

  int checks = 0, fails = 0;
  logic l_rxs, l_txs, l_err, l_req;

  emac_regfile #(.ADDR_W(ADDR_W), .STATION_ADDR(STA)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(idx * 4); bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    l_rxs = rx_start; l_txs = tx_start; l_err = bus_err; l_req = mgmt_req;
  endtask

  task automatic rd(input string req, input int idx, input logic [31:0] exp);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(idx * 4);
    #1 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
    l_err = bus_err;
  endtask

  function automatic bit mapped(input int i);
    case (i)
      1, 2, 4, 5, 9, 16, 17, 25, 33, 49, 57, 58, 59, 81, 83, 84, 96, 97, 98, 192, 194: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rst(input int i);
    case (i)
      9:   return 32'hF000_0000;
      25:  return 32'hC000_0000;
      33:  return 32'h05EE_0001;
      57:  return STA[47:16];
      58:  return {STA[15:0], 16'h8808};
      59:  return 32'h0001_0000;
      83:  return 32'h600;
      84:  return 32'h500;
      194: return 32'h6;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_wr(input int i, input logic [31:0] v);
    case (i)
      2, 57:   return v;
      17:      return v & 32'hFE;
      25:      return v[31] ? 32'hC000_0000 : 32'h0;
      33:      return v & 32'h07FF_003F;
      58:      return (v | 32'hFFFF) & 32'hFFFF_8808;
      59:      return (v & 32'hFFFF) | 32'h1_0000;
      81:      return v & 32'h3;
      83:      return 32'h600;
      84:      return (v & 32'h3FC) | 32'h400;
      96, 97:  return v & ~32'h3;
      98:      return v & 32'h7F0;
      192:     return v & 32'h53;
      194:     return v[1] ? 32'h6 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset irq", {31'b0, irq}, 32'h0);
    chk("R11 reset err", {31'b0, bus_err}, 32'h0);
    chk("R12 reset rx ptr", rx_desc_ptr, 32'h0);
    chk("R12 reset tx ptr", tx_desc_ptr, 32'h0);

    // R1 reset values over the whole index space
    for (int i = 0; i < (1 << (ADDR_W - 2)); i++) begin
      rd("R1 reset read", i, exp_rst(i));
      chk("R11 err on read", {31'b0, l_err}, {31'b0, ~mapped(i)});
    end

    // R11 unmapped writes
    for (int i = 0; i < (1 << (ADDR_W - 2)); i++) begin
      if (!mapped(i)) begin
        wr(i, 32'hFFFF_FFFF);
        chk("R11 err on write", {31'b0, l_err}, 32'h1);
        rd("R11 unmapped reads 0", i, 32'h0);
      end
    end

    // R7 R8 R12 write masks
    for (int i = 0; i < 200; i++) begin
      if (i inside {2, 17, 25, 33, 57, 58, 59, 81, 83, 84, 96, 97, 98, 192, 194}) begin
        for (int p = 0; p < 4; p++) begin
          logic [31:0] v;
          v = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 : (p == 2) ? 32'hA5A5_A5A7 : 32'h5A5A_5A5A;
          wr(i, v);
          chk("R7 R8 no err", {31'b0, l_err}, 32'h0);
          rd("R7 R8 masked readback", i, exp_wr(i, v));
          if (i == 96) chk("R12 rx ptr", rx_desc_ptr, v & ~32'h3);
          if (i == 97) chk("R12 tx ptr", tx_desc_ptr, v & ~32'h3);
        end
      end
    end

    // R2 R3 events and mask
    wr(2, 32'h0);
    wr(1, 32'hFFFF_FFFF);
    rd("R2 cleared", 1, 32'h0);
    ev_set = 32'h0F00_0001;
    @(negedge clk);
    ev_set = 32'h0;
    rd("R2 set vector", 1, 32'h0F00_0001);
    chk("R3 masked off", {31'b0, irq}, 32'h0);
    wr(2, 32'h0100_0000);
    chk("R3 irq high", {31'b0, irq}, 32'h1);
    wr(1, 32'h0100_0000);
    rd("R2 w1c one bit", 1, 32'h0E00_0001);
    chk("R3 irq low after clear", {31'b0, irq}, 32'h0);
    ev_set = 32'h1;
    wr(1, 32'h1);
    ev_set = 32'h0;
    rd("R2 set wins", 1, 32'h0E00_0001);
    wr(1, 32'hFFFF_FFFF);
    rd("R2 clear all", 1, 32'h0);

    // R9 transmit control
    wr(49, 32'h1);
    rd("R9 gra event", 1, 32'h1000_0000);
    rd("R9 tcr stored", 49, 32'h1);
    wr(1, 32'hFFFF_FFFF);
    wr(49, 32'h2);
    rd("R9 no gra", 1, 32'h0);
    rd("R9 tcr stored 2", 49, 32'h2);

    // R5 R6 R4 active registers and enable
    wr(4, 32'h0);
    chk("R5 no rx strobe disabled", {31'b0, l_rxs}, 32'h0);
    rd("R5 disabled reads 0", 4, 32'h0);
    wr(5, 32'h0);
    chk("R6 no tx strobe disabled", {31'b0, l_txs}, 32'h0);
    wr(9, 32'h2);
    rd("R4 ctl stored", 9, 32'h2);
    wr(4, 32'h0);
    chk("R5 rx strobe", {31'b0, l_rxs}, 32'h1);
    rd("R5 active reads", 4, 32'h0100_0000);
    wr(4, 32'h0);
    chk("R5 no strobe when active", {31'b0, l_rxs}, 32'h0);
    wr(5, 32'h0);
    chk("R6 tx strobe", {31'b0, l_txs}, 32'h1);
    rd("R6 reads 0", 5, 32'h0);
    wr(9, 32'h0);
    rd("R4 disable clears rx active", 4, 32'h0);
    wr(96, 32'h0000_3000);
    wr(9, 32'h0);
    chk("R4 rx ptr reload", rx_desc_ptr, 32'h0000_3000);

    // R10 management frames
    wr(16, 32'h2A94_0000);
    chk("R10 req", {31'b0, l_req}, 32'h1);
    chk("R10 rd", {31'b0, mgmt_rd}, 32'h1);
    chk("R10 addr", {22'b0, mgmt_addr}, 32'h2A5);
    mgmt_done = 1'b1; mgmt_rdata = 16'hBEEF;
    @(negedge clk);
    mgmt_done = 1'b0;
    chk("R10 req one cycle", {31'b0, mgmt_req}, 32'h0);
    rd("R10 read deposit", 16, 32'h2A94_BEEF);
    rd("R10 mii event", 1, 32'h0080_0000);
    wr(1, 32'hFFFF_FFFF);
    wr(16, 32'h0A94_1234);
    chk("R10 write op", {31'b0, mgmt_rd}, 32'h0);
    chk("R10 wdata", {16'b0, mgmt_wdata}, 32'h1234);
    mgmt_done = 1'b1; mgmt_rdata = 16'hFFFF;
    @(negedge clk);
    mgmt_done = 1'b0;
    rd("R10 write keeps data", 16, 32'h0A94_1234);

    // R4 soft reset
    wr(2, 32'hFFFF_FFFF);
    wr(33, 32'h0);
    chk("R4 irq before reset", {31'b0, irq}, 32'h1);
    wr(9, 32'h3);
    chk("R4 irq after reset", {31'b0, irq}, 32'h0);
    chk("R4 ptr after reset", rx_desc_ptr, 32'h0);
    rd("R4 ctl reset", 9, 32'hF000_0000);
    rd("R4 rcr reset", 33, 32'h05EE_0001);
    rd("R4 mask reset", 2, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule